// File: doc/BRIEF.md
# Instruction Cycle Controller

This block is the control unit and register set of a small accumulator machine. It runs each instruction through a fixed series of subcycles. Fetch reads the word at the program counter and moves it into the instruction register. Indirect runs only when the instruction asks for it, and reads a pointer word. Execute performs the operation. A short check step follows, and from there the block may enter the interrupt subcycle, which saves the program counter to a stack in memory and jumps to a fixed handler. It talks to one single-port synchronous memory through an address, read and write strobes, read and write data, and a ready handshake. Every access waits in its state until ready is seen.

The instruction word is 16 bits wide: one indirect flag, a 3-bit operation code and a 12-bit address field. The memory address register, the memory buffer register, the program counter, a one-field instruction register, the accumulator, the stack pointer and the interrupt enable flag are all held inside the block. The effective address always sits in the low bits of the buffer register. After a direct fetch it is the instruction's own address field; after an indirect read it is the pointer that came back from memory.

Top module: `icc_top`

## Requirements
- R1: Fetch loads the address register from the program counter, reads memory there, and places the returned word in the buffer register and its operation field in the instruction register. The first access after reset is a read of address 0.
- R2: The program counter advances by exactly one on each completed fetch read, so instructions that do not jump are fetched from consecutive addresses.
- R3: Word layout: bit 15 is the indirect flag, bits 14:12 the operation code, bits 11:0 the address field. The codes are 0 load, 1 store, 2 add, 3 jump and 4 enable interrupts. Codes 5 to 7 do nothing and make no memory access in execute.
- R4: When bit 15 of the fetched word is 1, one extra read is made at the address field. The low 12 bits of the returned word become the effective address; its upper 4 bits are ignored.
- R5: Load copies the word at the effective address into the accumulator. Add adds it to the accumulator modulo 2^16. Store writes the accumulator to the effective address.
- R6: Jump sets the program counter to the effective address, and the next fetch reads from there.
- R7: Interrupt requests are looked at only once per instruction, after execute, and only while the enable flag is 1. Reset clears the flag. Taking an interrupt raises the acknowledge output for exactly one cycle and clears the flag.
- R8: The interrupt subcycle writes the program counter, zero-extended to 16 bits, to the address held in the stack pointer. That saved value is the address of the next instruction, or the jump target. The stack pointer starts at 0xFFF after reset and decreases by one after each save.
- R9: After the save the program counter holds the handler address (0x100 by default), and the next access is a fetch from it.
- R10: While an access waits for ready, its strobe, address and write data stay unchanged. Read and write strobes are never high together.
- R11: While reset (active low, synchronous) is held, both strobes and the acknowledge are low. Releasing reset restarts fetching at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Memory address, taken from the address register |
| mem_rdata | input | 16 | Read data, used in the cycle ready is high |
| mem_wdata | output | 16 | Write data, taken from the buffer register |
| mem_rd | output | 1 | Read strobe, held until ready |
| mem_wr | output | 1 | Write strobe, held until ready |
| mem_ready | input | 1 | Memory completes the current access |
| irq | input | 1 | Interrupt request, level |
| irq_ack | output | 1 | One-cycle pulse when an interrupt is taken |

## Verification
The bound checker watches several rules on every cycle. Strobe, address and write data hold steady while ready is low, and the two strobes never overlap. The fetch address equals the program counter and the counter steps by one per fetch. An acknowledge comes only after an enabled request and is followed by a write of the old program counter to the stack slot, with the enable flag cleared. Each completed save leaves the program counter at the handler and the stack pointer one lower. The arithmetic results, the choice of effective address between direct and indirect words, the masking of requests before interrupts are enabled, the stack pointer walking down across two interrupts, the inertness of the spare codes and the restart after a reset in mid-run can only be shown by the bench's programs and their memory traces.

// File: rtl/icc_pkg.sv
// Package: shared encodings for the instruction cycle controller.
// Assumes a 16-bit word laid out as {indirect, opcode[2:0], address[11:0]}.
package icc_pkg;

    // Width of the operation field inside an instruction word.
    localparam int OPC_W = 3;

    // Subcycle states of the sequencer.
    typedef enum logic [3:0] {
        ST_FADDR  = 4'd0,   // fetch: address register <- program counter
        ST_FREAD  = 4'd1,   // fetch: read instruction word
        ST_DECODE = 4'd2,   // load IR, choose indirect or execute
        ST_INDIR  = 4'd3,   // indirect: read pointer word
        ST_EXEC   = 4'd4,   // execute: dispatch on opcode
        ST_OPRD   = 4'd5,   // execute: operand read
        ST_OPWR   = 4'd6,   // execute: operand write
        ST_CHECK  = 4'd7,   // end of instruction: sample interrupt
        ST_INTR   = 4'd8,   // interrupt: stage PC and stack pointer
        ST_SAVE   = 4'd9    // interrupt: write saved PC
    } state_e;

    // Operation codes.
    typedef enum logic [OPC_W-1:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_ADD   = 3'd2,
        OP_JUMP  = 3'd3,
        OP_ION   = 3'd4
    } op_e;

    // Source select for the memory address register.
    typedef enum logic [1:0] {
        MAR_HOLD = 2'd0,
        MAR_PC   = 2'd1,
        MAR_EA   = 2'd2,
        MAR_SP   = 2'd3
    } mar_sel_e;

    // Source select for the memory buffer register.
    typedef enum logic [1:0] {
        MBR_HOLD = 2'd0,
        MBR_MEM  = 2'd1,
        MBR_ACC  = 2'd2,
        MBR_PC   = 2'd3
    } mbr_sel_e;

    // Register-transfer controls issued by the sequencer each cycle.
    typedef struct packed {
        mar_sel_e mar_sel;
        mbr_sel_e mbr_sel;
        logic     ir_ld;
        logic     pc_inc;
        logic     pc_ea;
        logic     pc_vec;
        logic     acc_ld;
        logic     acc_add;
        logic     ie_set;
        logic     ie_clr;
        logic     sp_dec;
    } ctl_t;

endpackage

// File: rtl/icc_seq.sv
// Module: icc_seq
// Subcycle sequencer. Walks fetch, optional indirect, execute, the
// end-of-instruction check and the interrupt subcycle, and emits one
// control word per cycle for the register block. Every memory access
// state waits until mem_ready is seen high.
// Assumes: mbr_ind is the indirect flag of the buffer register, and
// ir_op is the opcode already held in the instruction register.
module icc_seq
    import icc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mem_ready,
    input  logic             mbr_ind,
    input  logic [OPC_W-1:0] ir_op,
    input  logic             ie,
    input  logic             irq,
    output state_e           state,
    output ctl_t             ctl,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             irq_ack
);

    state_e state_q;
    state_e state_d;

    // State register; reset enters the fetch subcycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FADDR;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and register-transfer controls for the present subcycle.
    always_comb begin
        state_d = state_q;
        ctl     = '0;
        unique case (state_q)
            ST_FADDR: begin
                ctl.mar_sel = MAR_PC;
                state_d     = ST_FREAD;
            end
            ST_FREAD: begin
                if (mem_ready) begin
                    ctl.mbr_sel = MBR_MEM;
                    ctl.pc_inc  = 1'b1;
                    state_d     = ST_DECODE;
                end
            end
            ST_DECODE: begin
                ctl.ir_ld   = 1'b1;
                ctl.mar_sel = MAR_EA;
                state_d     = mbr_ind ? ST_INDIR : ST_EXEC;
            end
            ST_INDIR: begin
                if (mem_ready) begin
                    ctl.mbr_sel = MBR_MEM;
                    state_d     = ST_EXEC;
                end
            end
            ST_EXEC: begin
                case (ir_op)
                    OP_LOAD, OP_ADD: begin
                        ctl.mar_sel = MAR_EA;
                        state_d     = ST_OPRD;
                    end
                    OP_STORE: begin
                        ctl.mar_sel = MAR_EA;
                        ctl.mbr_sel = MBR_ACC;
                        state_d     = ST_OPWR;
                    end
                    OP_JUMP: begin
                        ctl.pc_ea = 1'b1;
                        state_d   = ST_CHECK;
                    end
                    OP_ION: begin
                        ctl.ie_set = 1'b1;
                        state_d    = ST_CHECK;
                    end
                    default: begin
                        state_d = ST_CHECK;
                    end
                endcase
            end
            ST_OPRD: begin
                if (mem_ready) begin
                    ctl.acc_ld  = (ir_op == OP_LOAD);
                    ctl.acc_add = (ir_op == OP_ADD);
                    state_d     = ST_CHECK;
                end
            end
            ST_OPWR: begin
                if (mem_ready) begin
                    state_d = ST_CHECK;
                end
            end
            ST_CHECK: begin
                state_d = (irq && ie) ? ST_INTR : ST_FADDR;
            end
            ST_INTR: begin
                ctl.mbr_sel = MBR_PC;
                ctl.mar_sel = MAR_SP;
                ctl.ie_clr  = 1'b1;
                state_d     = ST_SAVE;
            end
            ST_SAVE: begin
                if (mem_ready) begin
                    ctl.sp_dec = 1'b1;
                    ctl.pc_vec = 1'b1;
                    state_d    = ST_FADDR;
                end
            end
            default: begin
                state_d = ST_FADDR;
            end
        endcase
    end

    // Memory strobes and acknowledge follow the present state only.
    always_comb begin
        mem_rd  = (state_q == ST_FREAD) || (state_q == ST_INDIR) || (state_q == ST_OPRD);
        mem_wr  = (state_q == ST_OPWR) || (state_q == ST_SAVE);
        irq_ack = (state_q == ST_INTR);
    end

    assign state = state_q;

endmodule

// File: rtl/icc_acc.sv
// Module: icc_acc
// Accumulator with load and wrap-around add. The add result width is
// the data width; carry out is discarded.
// Assumes ld and add are never requested in the same cycle.
module icc_acc #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic              add,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] acc
);

    logic [DATA_W-1:0] acc_q;

    // Accumulator update: load replaces, add accumulates modulo 2^DATA_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (ld) begin
            acc_q <= din;
        end else if (add) begin
            acc_q <= acc_q + din;
        end
    end

    assign acc = acc_q;

endmodule

// File: rtl/icc_dpath.sv
// Module: icc_dpath
// Register block: program counter, address and buffer registers,
// opcode register, stack pointer and interrupt enable flag, plus the
// accumulator instance. Performs the transfers selected by the control
// word from the sequencer.
// Assumes DATA_W = 1 + OPC_W + ADDR_W, with the indirect flag at the
// top bit and the address field at the bottom.
module icc_dpath
    import icc_pkg::*;
#(
    parameter int                ADDR_W       = 12,
    parameter int                DATA_W       = 16,
    parameter logic [ADDR_W-1:0] SP_INIT      = '1,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mbr_ind,
    output logic [OPC_W-1:0]  ir_op,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] sp,
    output logic              ie
);

    localparam int PAD_W  = DATA_W - ADDR_W;
    localparam int OPC_HI = DATA_W - 2;

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] mar_q;
    logic [DATA_W-1:0] mbr_q;
    logic [OPC_W-1:0]  ir_q;
    logic [ADDR_W-1:0] sp_q;
    logic              ie_q;
    logic [DATA_W-1:0] acc;
    logic [ADDR_W-1:0] ea;

    // Effective address is always the low field of the buffer register.
    assign ea = mbr_q[ADDR_W-1:0];

    // Program counter: vector, jump target or fetch increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (ctl.pc_vec) begin
            pc_q <= HANDLER_ADDR;
        end else if (ctl.pc_ea) begin
            pc_q <= ea;
        end else if (ctl.pc_inc) begin
            pc_q <= pc_q + 1'b1;
        end
    end

    // Memory address register source selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_q <= '0;
        end else begin
            case (ctl.mar_sel)
                MAR_PC:  mar_q <= pc_q;
                MAR_EA:  mar_q <= ea;
                MAR_SP:  mar_q <= sp_q;
                default: mar_q <= mar_q;
            endcase
        end
    end

    // Memory buffer register source selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mbr_q <= '0;
        end else begin
            case (ctl.mbr_sel)
                MBR_MEM: mbr_q <= mem_rdata;
                MBR_ACC: mbr_q <= acc;
                MBR_PC:  mbr_q <= {{PAD_W{1'b0}}, pc_q};
                default: mbr_q <= mbr_q;
            endcase
        end
    end

    // Instruction register keeps only the opcode; the address stays in MBR.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (ctl.ir_ld) begin
            ir_q <= mbr_q[OPC_HI -: OPC_W];
        end
    end

    // Stack pointer steps down after every completed save.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= SP_INIT;
        end else if (ctl.sp_dec) begin
            sp_q <= sp_q - 1'b1;
        end
    end

    // Interrupt enable flag: clear wins over set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= 1'b0;
        end else if (ctl.ie_clr) begin
            ie_q <= 1'b0;
        end else if (ctl.ie_set) begin
            ie_q <= 1'b1;
        end
    end

    icc_acc #(
        .DATA_W (DATA_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ctl.acc_ld),
        .add   (ctl.acc_add),
        .din   (mem_rdata),
        .acc   (acc)
    );

    assign mem_addr  = mar_q;
    assign mem_wdata = mbr_q;
    assign mbr_ind   = mbr_q[DATA_W-1];
    assign ir_op     = ir_q;
    assign pc        = pc_q;
    assign sp        = sp_q;
    assign ie        = ie_q;

endmodule

// File: rtl/icc_top.sv
// Module: icc_top
// Instruction cycle controller for a small accumulator machine. Joins
// the subcycle sequencer to the register block and exposes a single
// synchronous memory port with a ready handshake and an interrupt
// request/acknowledge pair.
// Assumes the memory holds mem_rdata valid in any cycle mem_ready is high.
module icc_top
    import icc_pkg::*;
#(
    parameter int                ADDR_W       = 12,
    parameter logic [ADDR_W-1:0] SP_INIT      = '1,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 'h100
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic [ADDR_W-1:0]             mem_addr,
    input  logic [1+icc_pkg::OPC_W+ADDR_W-1:0] mem_rdata,
    output logic [1+icc_pkg::OPC_W+ADDR_W-1:0] mem_wdata,
    output logic                          mem_rd,
    output logic                          mem_wr,
    input  logic                          mem_ready,
    input  logic                          irq,
    output logic                          irq_ack
);

    localparam int DATA_W = 1 + OPC_W + ADDR_W;

    state_e            state;
    ctl_t              ctl;
    logic              mbr_ind;
    logic [OPC_W-1:0]  ir_op;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] sp;
    logic              ie;

    icc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_ready (mem_ready),
        .mbr_ind   (mbr_ind),
        .ir_op     (ir_op),
        .ie        (ie),
        .irq       (irq),
        .state     (state),
        .ctl       (ctl),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .irq_ack   (irq_ack)
    );

    icc_dpath #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .SP_INIT      (SP_INIT),
        .HANDLER_ADDR (HANDLER_ADDR)
    ) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mbr_ind   (mbr_ind),
        .ir_op     (ir_op),
        .pc        (pc),
        .sp        (sp),
        .ie        (ie)
    );

endmodule

// File: rtl/icc_chk.sv
// Module: icc_chk
// Protocol and sequencing checker bound into icc_top. Observes the
// memory port, the interrupt pair and the top-level state, PC, stack
// pointer and enable flag.
module icc_chk
    import icc_pkg::*;
#(
    parameter int                ADDR_W       = 12,
    parameter int                DATA_W       = 16,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 'h100
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_ready,
    input logic              irq,
    input logic              irq_ack,
    input state_e            state,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] sp,
    input logic              ie
);

    localparam int PAD_W = DATA_W - ADDR_W;

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

    // R10
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R1
    fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FREAD && mem_rd) |-> (mem_addr == pc));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FREAD && mem_ready) |=> (pc == $past(pc) + 1'b1));

    // R7
    ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> ($past(irq) && $past(ie)));

    // R7
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (!irq_ack && !ie));

    // R8
    save_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (mem_wr && mem_addr == $past(sp)
                     && mem_wdata == {{PAD_W{1'b0}}, $past(pc)}));

    // R9
    vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAVE && mem_ready) |=> (pc == HANDLER_ADDR && sp == $past(sp) - 1'b1));

endmodule

bind icc_top icc_chk #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .HANDLER_ADDR (HANDLER_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_ready (mem_ready),
    .irq       (irq),
    .irq_ack   (irq_ack),
    .state     (state),
    .pc        (pc),
    .sp        (sp),
    .ie        (ie)
);

// File: tb/sim_icc_top.sv
`timescale 1ns/1ps
module sim_icc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic [15:0] mem_wdata;
    logic        mem_rd;
    logic        mem_wr;
    logic        mem_ready = 1'b0;
    logic        irq = 1'b0;
    logic        irq_ack;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    // Memory model state and access trace.
    logic [15:0] mem [0:4095];
    int          ws = 0;
    int          wcnt = 0;
    int          ack_n = 0;
    int          acc_n = 0;
    logic [11:0] acc_addr [0:255];
    logic        acc_wr   [0:255];
    logic [15:0] acc_data [0:255];

    // Vector: {ind, ws[1:0], a[15:0], b[15:0], expected[15:0]}
    localparam logic [50:0] VECS [0:5] = '{
        {1'b0, 2'd0, 16'h0005, 16'h0003, 16'h0008},
        {1'b1, 2'd0, 16'h1234, 16'h0001, 16'h1235},
        {1'b0, 2'd2, 16'hFFFF, 16'h0002, 16'h0001},
        {1'b1, 2'd3, 16'h8000, 16'h8000, 16'h0000},
        {1'b0, 2'd1, 16'h00FF, 16'h0F01, 16'h1000},
        {1'b1, 2'd1, 16'h7FFF, 16'h0001, 16'h8000}
    };

    icc_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_ready (mem_ready),
        .irq       (irq),
        .irq_ack   (irq_ack)
    );

    always #4 clk = ~clk;

    // Memory responder: decides ready and data at the falling edge.
    always @(negedge clk) begin
        if (mem_rd || mem_wr) begin
            if (wcnt >= ws) begin
                mem_ready = 1'b1;
                wcnt = 0;
                if (mem_rd) mem_rdata = mem[mem_addr];
                if (mem_wr) mem[mem_addr] = mem_wdata;
                if (acc_n < 256) begin
                    acc_addr[acc_n] = mem_addr;
                    acc_wr[acc_n]   = mem_wr;
                    acc_data[acc_n] = mem_wr ? mem_wdata : mem[mem_addr];
                    acc_n = acc_n + 1;
                end
            end else begin
                mem_ready = 1'b0;
                wcnt = wcnt + 1;
            end
        end else begin
            mem_ready = 1'b0;
            wcnt = 0;
        end
        if (irq_ack) ack_n = ack_n + 1;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int k = 0; k < 4096; k++) mem[k] = 16'h0000;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        acc_n = 0;
        ack_n = 0;
        rst_n = 1'b1;
    endtask

    // Index of the k-th write in the trace, or -1.
    function automatic int nth_write(input int k);
        int seen = 0;
        for (int j = 0; j < acc_n; j++) begin
            if (acc_wr[j]) begin
                if (seen == k) return j;
                seen = seen + 1;
            end
        end
        return -1;
    endfunction

    task automatic load_arith(input bit ind, input logic [15:0] a, input logic [15:0] b);
        clear_mem();
        mem[12'h000] = {ind, 3'd0, 12'h200};   // load
        mem[12'h001] = {ind, 3'd2, 12'h201};   // add
        mem[12'h002] = {1'b0, 3'd1, 12'h300};  // store
        mem[12'h003] = {1'b0, 3'd3, 12'h003};  // jump to self
        if (ind) begin
            mem[12'h200] = 16'hF210;           // upper bits must be ignored
            mem[12'h201] = 16'hF211;
            mem[12'h210] = a;
            mem[12'h211] = b;
        end else begin
            mem[12'h200] = a;
            mem[12'h201] = b;
        end
    endtask

    initial begin
        int wi;
        int wj;

        // Vector table: load / add / store, direct and indirect, with wait states.
        for (int i = 0; i < 6; i++) begin
            logic [50:0] v;
            v = VECS[i];
            load_arith(v[50], v[47:32], v[31:16]);
            ws = int'(v[49:48]);
            do_reset();
            run(250);
            chk(mem[12'h300] == v[15:0], $sformatf("R5 vec%0d stored sum", i), mem[12'h300], v[15:0]);
            chk(acc_addr[1] == 12'h200 && !acc_wr[1], $sformatf("R1 vec%0d operand/pointer read", i),
                acc_addr[1], 12'h200);
            if (v[50])
                chk(acc_addr[2] == 12'h210, $sformatf("R4 vec%0d effective address", i), acc_addr[2], 12'h210);
            else
                chk(acc_addr[2] == 12'h001, $sformatf("R2 vec%0d next fetch", i), acc_addr[2], 12'h001);
            chk(acc_addr[acc_n-1] == 12'h003 && !acc_wr[acc_n-1], $sformatf("R6 vec%0d jump loop", i),
                acc_addr[acc_n-1], 12'h003);
        end

        // R11: strobes quiet during reset, first access is a fetch at 0.
        ws = 0;
        load_arith(1'b0, 16'h0011, 16'h0022);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(!mem_rd && !mem_wr && !irq_ack, "R11 outputs idle in reset", {mem_rd, mem_wr, irq_ack}, 0);
        acc_n = 0;
        rst_n = 1'b1;
        run(40);
        chk(acc_addr[0] == 12'h000 && !acc_wr[0], "R11 first fetch address", acc_addr[0], 0);

        // R11: reset in mid-run restarts the program.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk(!mem_rd && !mem_wr, "R11 strobes low after mid-run reset", {mem_rd, mem_wr}, 0);
        mem[12'h300] = 16'h0000;
        acc_n = 0;
        @(negedge clk);
        rst_n = 1'b1;
        run(120);
        chk(acc_addr[0] == 12'h000, "R11 restart fetch at 0", acc_addr[0], 0);
        chk(mem[12'h300] == 16'h0033, "R11 rerun result", mem[12'h300], 16'h0033);

        // R3: spare opcode makes no access.
        clear_mem();
        mem[12'h000] = 16'h0200;
        mem[12'h001] = 16'h5300;
        mem[12'h002] = 16'h1301;
        mem[12'h003] = 16'h3003;
        mem[12'h200] = 16'h0055;
        mem[12'h300] = 16'hAAAA;
        ws = 1;
        do_reset();
        run(150);
        chk(mem[12'h300] == 16'hAAAA, "R3 spare code left memory alone", mem[12'h300], 16'hAAAA);
        chk(mem[12'h301] == 16'h0055, "R3 store after spare code", mem[12'h301], 16'h0055);
        chk(acc_addr[3] == 12'h002, "R3 spare code no execute access", acc_addr[3], 12'h002);

        // R7/R8/R9: request held from reset is masked until enable.
        clear_mem();
        mem[12'h000] = 16'h0200;
        mem[12'h001] = 16'h1300;
        mem[12'h002] = 16'h4000;
        mem[12'h003] = 16'h3003;
        mem[12'h100] = 16'h3100;
        mem[12'h200] = 16'h0007;
        ws = 0;
        irq = 1'b1;
        do_reset();
        run(300);
        irq = 1'b0;
        chk(acc_wr[3] && acc_addr[3] == 12'h300 && acc_data[3] == 16'h0007,
            "R7 masked before enable", acc_addr[3], 12'h300);
        chk(acc_wr[5] && acc_addr[5] == 12'hFFF, "R8 save address", acc_addr[5], 12'hFFF);
        chk(acc_data[5] == 16'h0003, "R8 saved PC", acc_data[5], 16'h0003);
        chk(!acc_wr[6] && acc_addr[6] == 12'h100, "R9 handler fetch", acc_addr[6], 12'h100);
        chk(ack_n == 1, "R7 one acknowledge, flag cleared", ack_n, 1);

        // R8: second interrupt saves below the first.
        clear_mem();
        mem[12'h000] = 16'h4000;
        mem[12'h001] = 16'h3001;
        mem[12'h100] = 16'h4000;
        mem[12'h101] = 16'h3101;
        ws = 2;
        irq = 1'b1;
        do_reset();
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            if (irq_ack) break;
        end
        irq = 1'b0;
        run(80);
        chk(ack_n == 1, "R7 no request after drop", ack_n, 1);
        irq = 1'b1;
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            if (irq_ack) break;
        end
        irq = 1'b0;
        run(60);
        wi = nth_write(0);
        wj = nth_write(1);
        chk(wi >= 0 && acc_addr[wi] == 12'hFFF && acc_data[wi] == 16'h0001, "R8 first save",
            (wi >= 0) ? acc_data[wi] : -1, 16'h0001);
        chk(wj >= 0 && acc_addr[wj] == 12'hFFE, "R8 stack pointer decrement",
            (wj >= 0) ? acc_addr[wj] : -1, 12'hFFE);
        chk(wj >= 0 && acc_data[wj] == 16'h0101, "R8 saved jump target",
            (wj >= 0) ? acc_data[wj] : -1, 16'h0101);
        chk(wj >= 0 && acc_addr[wj+1] == 12'h100 && !acc_wr[wj+1], "R9 second handler entry",
            (wj >= 0) ? acc_addr[wj+1] : -1, 12'h100);
        chk(ack_n == 2, "R7 acknowledge count", ack_n, 2);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule